// File: doc/BRIEF.md
# Paging Decoder Status and Control Register

This block is the status/control register pair of a paging-decoder core. Both registers sit behind one bus address. A read access returns an 8-bit status word that gathers the decoder's events. A write access loads an 8-bit control word. Its fields drive the decoder's forced-termination, non-volatile programming enable, monitor source, continuous receive, power and interrupt-mask functions.

Each status bit has its own rule for clear-on-read:
- The call bit stays set while a further call is waiting.
- The data-available bit stays set while the buffer pointers still differ.
- The alert, drained/full and timer bits always clear on a read.
- The out-of-range and monitor bits follow their live inputs and a read does not touch them.

The block raises one interrupt request line from the interrupt-capable status bits. Three of those bits can be masked.

Top module: `pgr_stat_ctrl`

## Requirements
- R1: After a synchronous active-low reset the status word reads 0x00, every control output is 0 and `irq` is low.
- R2: A write (`bus_sel`=1, `bus_wr`=1) loads `bus_wdata` into the control word at the clock edge. Bit 0 is `force_term`, bit 1 `prog_en`, bit 2 `mon_sel`, bit 3 `rx_cont` and bit 4 `dec_on`. Bits 5, 6 and 7 mask the out-of-range, monitor and timer interrupts. Reads return status, never the control word.
- R3: A `call_start` pulse sets status bit 0 (field bits 1:0 = 01) and does not raise `irq`.
- R4: A `call_rx` pulse sets status bit 0 and raises `irq`. A read clears bit 0 and that interrupt at the next edge, but only when `call_pend` is low. Status bit 1 always reads 0.
- R5: While `ptr_eq` is low, status bit 2 is set (field bits 3:2 = 01). A read clears bit 2 only while `ptr_eq` is high.
- R6: A rise of `ptr_eq` (buffer drained) sets bits 3:2 to 10. Any read clears bit 3.
- R7: A `buf_full` pulse sets bits 3:2 to 11. While bits 3:2 are nonzero, `irq` is high.
- R8: An `alert_to` pulse sets status bit 4, which raises `irq` and clears on any read.
- R9: Status bit 5 equals `oor` one cycle later and is never cleared by a read. It raises `irq` unless control bit 5 is set.
- R10: Status bit 6 equals `bat` one cycle later when control bit 2 is 0, and `rxe` when it is 1. A read does not clear it. It raises `irq` unless control bit 6 is set.
- R11: A `tick` pulse sets status bit 7, which clears on any read. It raises `irq` unless control bit 7 is set.
- R12: An event that arrives in the same cycle as a read leaves its status bit set.
- R13: A `term_done` pulse clears control bit 0 and keeps the other control bits. A write in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write control, 0 = read status |
| bus_wdata | input | 8 | Control word to load |
| bus_rdata | output | 8 | Current status word |
| call_start | input | 1 | Pulse: enabled user address matched |
| call_rx | input | 1 | Pulse: new call received |
| call_pend | input | 1 | Level: a second call is waiting |
| ptr_eq | input | 1 | Level: buffer read and write pointers equal |
| buf_full | input | 1 | Pulse: buffer full or overflowed |
| alert_to | input | 1 | Pulse: alert time-out expired |
| oor | input | 1 | Level: out-of-range condition |
| bat | input | 1 | Level: battery monitor input |
| rxe | input | 1 | Level: receiver enable output state |
| tick | input | 1 | Pulse: periodic timer event |
| term_done | input | 1 | Pulse: forced termination completed |
| force_term | output | 1 | Control bit 0 |
| prog_en | output | 1 | Control bit 1 |
| mon_sel | output | 1 | Control bit 2 |
| rx_cont | output | 1 | Control bit 3 |
| dec_on | output | 1 | Control bit 4 |
| irq | output | 1 | Interrupt request |

## Verification
The buffer field is the hardest state to reach from the ports. Bits 3 and 2 depend on the present level of `ptr_eq` and on its level one cycle earlier, and a read clears them in two different ways. The vector table therefore drives `ptr_eq` as a level that every step restates. It walks the field through 01, then a read while the pointers still differ, then the drained code 10, then the full code 11, and issues reads between these steps. Events that coincide with reads, and writes that coincide with `term_done`, are placed in the same cycle on purpose.

// File: rtl/pgr_sc_pkg.sv
// Package: shared widths, field positions and the control-word type for the
// paging decoder status/control register. Assumes an 8-bit register bus.
package pgr_sc_pkg;
    localparam int REG_W   = 8;
    localparam int EV_W    = 4;
    // status bit positions used by interrupt combination
    localparam int ST_CALL = 0;
    localparam int ST_AVL  = 2;
    localparam int ST_DRN  = 3;
    localparam int ST_ALR  = 4;
    localparam int ST_OOR  = 5;
    localparam int ST_MON  = 6;
    localparam int ST_TMR  = 7;

    typedef struct packed {
        logic mask_tmr;
        logic mask_mon;
        logic mask_oor;
        logic dec_on;
        logic rx_cont;
        logic mon_sel;
        logic prog_en;
        logic force_term;
    } ctl_t;
endpackage

// File: rtl/pgr_ctl_reg.sv
// Control word register. Loads on a write strobe. The forced-termination bit
// self-clears on term_done unless a write lands in the same cycle.
// Assumes wr_stb is a single-cycle strobe.
module pgr_ctl_reg
    import pgr_sc_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_stb,
    input  logic [W-1:0] wdata,
    input  logic         term_done,
    output ctl_t         ctl
);
    // hold control word; write beats self-clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl <= '0;
        else if (wr_stb)
            ctl <= ctl_t'(wdata);
        else if (term_done)
            ctl.force_term <= 1'b0;
    end

    // R13
    term_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (term_done && !wr_stb) |=> !ctl.force_term);
    // R2
    ctl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (ctl == $past(wdata)));
endmodule

// File: rtl/pgr_call_buf_stat.sv
// Status bits 3:0. It tracks the call indication, the hidden new-call interrupt
// flag and the buffer state field derived from pointer equality.
// Assumes ptr_eq is synchronous and high when the buffer is empty.
module pgr_call_buf_stat (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_stb,
    input  logic       call_start,
    input  logic       call_rx,
    input  logic       call_pend,
    input  logic       ptr_eq,
    input  logic       buf_full,
    output logic [3:0] stat_lo,
    output logic       call_irq
);
    logic call_seen, avail, drn, peq_q;
    logic drained, call_clr;

    assign drained  = ptr_eq & ~peq_q;
    assign call_clr = rd_stb & ~call_pend;

    // call indication: set on start or receipt, read clears unless pending
    always_ff @(posedge clk) begin
        if (!rst_n)                     call_seen <= 1'b0;
        else if (call_start || call_rx) call_seen <= 1'b1;
        else if (call_clr)              call_seen <= 1'b0;
    end

    // new-call interrupt flag, cleared together with the call bit
    always_ff @(posedge clk) begin
        if (!rst_n)        call_irq <= 1'b0;
        else if (call_rx)  call_irq <= 1'b1;
        else if (call_clr) call_irq <= 1'b0;
    end

    // previous pointer equality for drained detection
    always_ff @(posedge clk) begin
        if (!rst_n) peq_q <= 1'b1;
        else        peq_q <= ptr_eq;
    end

    // data-available bit: kept while pointers differ
    always_ff @(posedge clk) begin
        if (!rst_n)                avail <= 1'b0;
        else if (buf_full)         avail <= 1'b1;
        else if (drained)          avail <= 1'b0;
        else if (!ptr_eq)          avail <= 1'b1;
        else if (rd_stb)           avail <= 1'b0;
    end

    // drained/full bit: any read clears
    always_ff @(posedge clk) begin
        if (!rst_n)                  drn <= 1'b0;
        else if (buf_full || drained) drn <= 1'b1;
        else if (rd_stb)             drn <= 1'b0;
    end

    assign stat_lo = {drn, avail, 1'b0, call_seen};

    // R4
    call_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && call_pend && call_seen) |=> call_seen);
    // R5
    avail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_eq && !drained) |=> avail);
    // R6
    drn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !buf_full && !drained) |=> !drn);
    // R7
    full_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full |=> (stat_lo[3:2] == 2'b11));
endmodule

// File: rtl/pgr_evt_flags.sv
// Status bits 7:4. The alert and timer bits are sticky and clear on read.
// The out-of-range and monitor bits are registered copies of live levels.
// Assumes all event inputs are synchronous to clk.
module pgr_evt_flags
    import pgr_sc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_stb,
    input  logic            alert_to,
    input  logic            oor,
    input  logic            bat,
    input  logic            rxe,
    input  logic            tick,
    input  logic            mon_sel,
    output logic [EV_W-1:0] stat_hi
);
    logic alr, oor_q, mon_q, tmr;

    // alert time-out bit: event beats read clear
    always_ff @(posedge clk) begin
        if (!rst_n)        alr <= 1'b0;
        else if (alert_to) alr <= 1'b1;
        else if (rd_stb)   alr <= 1'b0;
    end

    // periodic timer bit: event beats read clear
    always_ff @(posedge clk) begin
        if (!rst_n)      tmr <= 1'b0;
        else if (tick)   tmr <= 1'b1;
        else if (rd_stb) tmr <= 1'b0;
    end

    // level bits follow their sources, untouched by reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oor_q <= 1'b0;
            mon_q <= 1'b0;
        end else begin
            oor_q <= oor;
            mon_q <= mon_sel ? rxe : bat;
        end
    end

    assign stat_hi = {tmr, mon_q, oor_q, alr};

    // R8
    alert_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alert_to |=> alr);
    // R11
    tick_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> tmr);
    // R9
    oor_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> (oor_q == $past(oor)));
    // R12
    tmr_read_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !tick) |=> !tmr);
endmodule

// File: rtl/pgr_irq_gen.sv
// Interrupt request: OR of the unmaskable events and the masked level or
// timer events. Assumes status and control are registered upstream.
module pgr_irq_gen
    import pgr_sc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] status,
    input  logic             call_irq,
    input  ctl_t             ctl,
    output logic             irq
);
    logic fixed_src, masked_src;

    // combine interrupt sources
    always_comb begin
        fixed_src  = call_irq | status[ST_AVL] | status[ST_DRN] | status[ST_ALR];
        masked_src = (status[ST_OOR] & ~ctl.mask_oor)
                   | (status[ST_MON] & ~ctl.mask_mon)
                   | (status[ST_TMR] & ~ctl.mask_tmr);
        irq        = fixed_src | masked_src;
    end

    // R3
    call_start_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[7:1] == 7'd0 && !call_irq) |-> !irq);
    // R9
    oor_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[ST_OOR] && !ctl.mask_oor) |-> irq);
endmodule

// File: rtl/pgr_stat_ctrl.sv
// Top: one-address status/control register pair for a paging decoder.
// A read returns status and clears bits at the following edge. A write loads
// control. Assumes bus_sel is a single-cycle strobe per access.
module pgr_stat_ctrl
    import pgr_sc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             call_start,
    input  logic             call_rx,
    input  logic             call_pend,
    input  logic             ptr_eq,
    input  logic             buf_full,
    input  logic             alert_to,
    input  logic             oor,
    input  logic             bat,
    input  logic             rxe,
    input  logic             tick,
    input  logic             term_done,
    output logic             force_term,
    output logic             prog_en,
    output logic             mon_sel,
    output logic             rx_cont,
    output logic             dec_on,
    output logic             irq
);
    logic            rd_stb, wr_stb, call_irq;
    logic [3:0]      stat_lo;
    logic [EV_W-1:0] stat_hi;
    ctl_t            ctl;

    assign rd_stb = bus_sel & ~bus_wr;
    assign wr_stb = bus_sel & bus_wr;

    pgr_ctl_reg u_ctl (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wdata(bus_wdata),
        .term_done(term_done), .ctl(ctl)
    );

    pgr_call_buf_stat u_cbs (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .call_start(call_start),
        .call_rx(call_rx), .call_pend(call_pend), .ptr_eq(ptr_eq),
        .buf_full(buf_full), .stat_lo(stat_lo), .call_irq(call_irq)
    );

    pgr_evt_flags u_evt (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .alert_to(alert_to),
        .oor(oor), .bat(bat), .rxe(rxe), .tick(tick), .mon_sel(ctl.mon_sel),
        .stat_hi(stat_hi)
    );

    assign bus_rdata = {stat_hi, stat_lo};

    pgr_irq_gen u_irq (
        .clk(clk), .rst_n(rst_n), .status(bus_rdata), .call_irq(call_irq),
        .ctl(ctl), .irq(irq)
    );

    assign force_term = ctl.force_term;
    assign prog_en    = ctl.prog_en;
    assign mon_sel    = ctl.mon_sel;
    assign rx_cont    = ctl.rx_cont;
    assign dec_on     = ctl.dec_on;

    // R4
    res_bit1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rdata[1]);
endmodule

// File: tb/pgr_stat_ctrl_bench.sv
`timescale 1ns/1ps
module pgr_stat_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 0, bus_wr = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic call_start = 0, call_rx = 0, call_pend = 0, ptr_eq = 1, buf_full = 0;
    logic alert_to = 0, oor = 0, bat = 0, rxe = 0, tick = 0, term_done = 0;
    logic force_term, prog_en, mon_sel, rx_cont, dec_on, irq;
    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pgr_stat_ctrl u_pgr_stat_ctrl (.*);

    localparam logic [10:0] E_CS = 11'h001, E_CR = 11'h002, E_PEND = 11'h004,
        E_PEQ = 11'h008, E_FULL = 11'h010, E_ALR = 11'h020, E_OOR = 11'h040,
        E_BAT = 11'h080, E_RXE = 11'h100, E_TICK = 11'h200;
    localparam logic R = 1'b1, N = 1'b0;
    // {rd, wr, wdata, events, expected status, expected irq}
    localparam int NV = 29;
    localparam logic [29:0] TBL [NV] = '{
        {N, N, 8'h00, E_PEQ,          8'h00, 1'b0}, // R1 idle
        {N, N, 8'h00, E_CS|E_PEQ,     8'h01, 1'b0}, // R3
        {R, N, 8'h00, E_PEQ,          8'h00, 1'b0}, // R3 read clears
        {N, N, 8'h00, E_CR|E_PEQ,     8'h01, 1'b1}, // R4
        {R, N, 8'h00, E_PEND|E_PEQ,   8'h01, 1'b1}, // R4 pending holds
        {R, N, 8'h00, E_PEQ,          8'h00, 1'b0}, // R4 cleared
        {N, N, 8'h00, 11'h000,        8'h04, 1'b1}, // R5 data available
        {R, N, 8'h00, 11'h000,        8'h04, 1'b1}, // R5 read keeps
        {N, N, 8'h00, E_PEQ,          8'h08, 1'b1}, // R6 drained
        {R, N, 8'h00, E_PEQ,          8'h00, 1'b0}, // R6 read clears
        {N, N, 8'h00, E_FULL|E_PEQ,   8'h0C, 1'b1}, // R7 full
        {R, N, 8'h00, E_PEQ,          8'h00, 1'b0}, // R7 read clears
        {N, N, 8'h00, E_ALR|E_PEQ,    8'h10, 1'b1}, // R8
        {R, N, 8'h00, E_ALR|E_PEQ,    8'h10, 1'b1}, // R12 event with read
        {R, N, 8'h00, E_PEQ,          8'h00, 1'b0}, // R8 read clears
        {N, N, 8'h00, E_OOR|E_PEQ,    8'h20, 1'b1}, // R9
        {R, N, 8'h00, E_OOR|E_PEQ,    8'h20, 1'b1}, // R9 read ignored
        {N, R, 8'h20, E_OOR|E_PEQ,    8'h20, 1'b0}, // R9 masked
        {N, R, 8'h00, E_PEQ,          8'h00, 1'b0}, // R9 follows level
        {N, N, 8'h00, E_BAT|E_PEQ,    8'h40, 1'b1}, // R10 bat source
        {N, N, 8'h00, E_RXE|E_PEQ,    8'h00, 1'b0}, // R10 rxe ignored
        {N, R, 8'h04, E_RXE|E_PEQ,    8'h00, 1'b0}, // R10 select rxe
        {N, N, 8'h00, E_RXE|E_PEQ,    8'h40, 1'b1}, // R10 rxe source
        {N, R, 8'h44, E_RXE|E_PEQ,    8'h40, 1'b0}, // R10 masked
        {N, R, 8'h00, E_PEQ,          8'h00, 1'b0}, // R10 back
        {N, N, 8'h00, E_TICK|E_PEQ,   8'h80, 1'b1}, // R11
        {N, R, 8'h80, E_PEQ,          8'h80, 1'b0}, // R11 masked
        {R, N, 8'h00, E_PEQ,          8'h00, 1'b0}, // R11 read clears
        {N, R, 8'h00, E_PEQ,          8'h00, 1'b0}  // R2 restore
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        bus_sel = 0; bus_wr = 0; bus_wdata = 0;
        {tick, rxe, bat, oor, alert_to, buf_full, call_pend, call_start, call_rx} = '0;
        ptr_eq = 1; term_done = 0;
    endtask

    function automatic logic [7:0] ctl_out();
        return {3'b000, dec_on, rx_cont, mon_sel, prog_en, force_term};
    endfunction

    initial begin
        idle();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 status", bus_rdata, 8'h00);
        chk("R1 ctl", ctl_out(), 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        rst_n = 1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            logic [10:0] ev;
            ev = TBL[i][19:9];
            bus_sel = TBL[i][29] | TBL[i][28];
            bus_wr = TBL[i][28];
            bus_wdata = TBL[i][27:20];
            {tick, rxe, bat, oor, alert_to, buf_full, ptr_eq, call_pend, call_rx, call_start} = ev[9:0];
            @(negedge clk);
            chk($sformatf("table step %0d status", i), bus_rdata, TBL[i][8:1]);
            chk($sformatf("table step %0d irq", i), {7'd0, irq}, {7'd0, TBL[i][0]});
        end
        idle();
        // R2 control fields and read returns status
        bus_sel = 1; bus_wr = 1; bus_wdata = 8'h1F;
        @(negedge clk);
        idle();
        chk("R2 ctl fields", ctl_out(), 8'h1F);
        chk("R2 read shows status", bus_rdata, 8'h00);
        // R13 self-clear keeps other bits
        term_done = 1;
        @(negedge clk);
        idle();
        chk("R13 term clears", ctl_out(), 8'h1E);
        // R13 write wins over term_done
        bus_sel = 1; bus_wr = 1; bus_wdata = 8'h01; term_done = 1;
        @(negedge clk);
        idle();
        chk("R13 write priority", ctl_out(), 8'h01);
        // R1 reset mid-run
        alert_to = 1;
        @(negedge clk);
        idle();
        chk("R8 before reset", bus_rdata, 8'h10);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        chk("R1 reset status", bus_rdata, 8'h00);
        chk("R1 reset ctl", ctl_out(), 8'h00);
        chk("R1 reset irq", {7'd0, irq}, 8'h00);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule